// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Trigger Modes

This block collects up to sixteen external request lines and presents a single interrupt to a processor. Each line carries its own trigger mode (active-low level, active-high level, falling edge or rising edge) and its own small priority number. Edge events are caught in a per-line latch that holds until software clears it by writing a command word naming the line. Level requests are never held: they follow the input.

A line takes part in arbitration when it is requesting, its priority is non-zero and its priority is no lower than a global threshold. Among those lines the highest priority wins, and on a tie the lower line number wins. Software reads the winner's number and priority from a status word, whose flag bit is set when nothing is pending. The interrupt output is a registered copy of the inverse of that flag. A single global enable gates all delivery.

Access is through a plain 32-bit word-addressed register port with a write strobe and a combinational read path. All request inputs are treated as asynchronous and pass through a two-stage synchronizer before any mode logic sees them.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, except the status word, which reads 0x00010000, and cpu_irq_o is 0.
- R2: Bit 0 of word 0 is the global enable; while it is 0 the status word reads 0x00010000 and cpu_irq_o is 0 whatever the sources do.
- R3: Words 1 and 2 hold 2-bit trigger modes, line n at word 1+n/8, bits (n mod 8)*2+1:(n mod 8)*2; code 00 requests while the input is low, 01 while it is high, 10 latches a falling edge, 11 latches a rising edge; unused bits 31:16 read zero.
- R4: Words 4 to 11 hold 3-bit priorities, line n at word 4+n/2, bits 2:0 for even n and bits 10:8 for odd n; all other bits read zero; priority 0 disables the line.
- R5: Word 12 bits 2:0 hold the threshold; a line is delivered only when its priority is greater than or equal to the threshold.
- R6: Among eligible lines the highest priority wins; on equal priority the lowest line number wins.
- R7: The status word at word 14 is read-only: bit 16 is 1 when nothing is pending and 0 otherwise, bits 10:8 give the winner's priority, bits 4:0 its line number, all other bits read zero (and the priority and number fields are zero when bit 16 is 1). Writes to it have no effect.
- R8: An edge-mode line stays pending after its input returns to the idle level until cleared; the opposite edge does not set it.
- R9: A write to word 13 with bit 8 set clears the latched edge of the line named in bits 3:0; with bit 8 clear the write has no effect. Word 13 reads zero.
- R10: A level-mode line is not latched: it stops requesting as soon as its input no longer matches the programmed polarity.
- R11: cpu_irq_o equals the inverse of status bit 16 delayed by one clock cycle.
- R12: Unused words 3 and 15 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NSRC | Asynchronous request lines |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| cpu_irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The assertions take for granted that the register port is driven with a known address and a write strobe of at most one cycle per access, and that a line whose mode is switched into an edge code may carry over its previous pending value until a clear command is issued. The stimulus keeps inside this by changing bus and request inputs only on the falling clock edge, by issuing a clear for every line it moves into an edge mode before relying on its latch, and by holding request inputs steady for several cycles so that the synchronizer delay has passed before any status read is compared.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   typedef enum logic [1:0] {
      TRIG_LOW  = 2'b00,
      TRIG_HIGH = 2'b01,
      TRIG_FALL = 2'b10,
      TRIG_RISE = 2'b11
   } trig_e;

   // word map
   localparam int unsigned A_ENABLE = 0;
   localparam int unsigned A_MODE0  = 1;
   localparam int unsigned A_LEVEL0 = 4;
   localparam int unsigned A_MASK   = 12;
   localparam int unsigned A_CLEAR  = 13;
   localparam int unsigned A_STATUS = 14;

   // field positions
   localparam int unsigned CLR_GO_BIT   = 8;
   localparam int unsigned CLR_SRC_W    = 4;
   localparam int unsigned ST_NOIRQ_BIT = 16;
   localparam int unsigned ST_LVL_LSB   = 8;
   localparam int unsigned ST_SRC_W     = 5;

   function automatic int unsigned mode_word(int unsigned n);
      return A_MODE0 + n / 8;
   endfunction

   function automatic int unsigned mode_off(int unsigned n);
      return (n % 8) * 2;
   endfunction

   function automatic int unsigned lvl_word(int unsigned n);
      return A_LEVEL0 + (n % 16) / 2;
   endfunction

   function automatic int unsigned lvl_off(int unsigned n);
      return (n / 16) * 16 + (n % 2) * 8;
   endfunction

endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
   import prio_irq_pkg::*;
#(
   parameter int unsigned NSRC   = 16,
   parameter int unsigned LVL_W  = 3,
   parameter int unsigned ADDR_W = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            addr_i,
   input  logic                         wr_i,
   input  logic [31:0]                  wdata_i,
   input  logic [31:0]                  status_i,
   output logic [31:0]                  rdata_o,
   output logic                         enable_o,
   output logic [NSRC-1:0][1:0]         mode_o,
   output logic [NSRC-1:0][LVL_W-1:0]   level_o,
   output logic [LVL_W-1:0]             mask_o,
   output logic [NSRC-1:0]              clr_o
);

   localparam logic [ADDR_W-1:0] AD_EN   = ADDR_W'(A_ENABLE);
   localparam logic [ADDR_W-1:0] AD_MASK = ADDR_W'(A_MASK);
   localparam logic [ADDR_W-1:0] AD_CLR  = ADDR_W'(A_CLEAR);
   localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STATUS);

   logic             en_q;
   logic [LVL_W-1:0] mask_q;
   logic             clr_go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mask_q <= '0;
      end else if (wr_i) begin
         if (addr_i == AD_EN)   en_q   <= wdata_i[0];
         if (addr_i == AD_MASK) mask_q <= wdata_i[LVL_W-1:0];
      end
   end

   assign enable_o = en_q;
   assign mask_o   = mask_q;
   assign clr_go   = wr_i && (addr_i == AD_CLR) && wdata_i[CLR_GO_BIT];

   for (genvar n = 0; n < NSRC; n++) begin : g_line
      localparam int unsigned MW = mode_word(n);
      localparam int unsigned MO = mode_off(n);
      localparam int unsigned LW = lvl_word(n);
      localparam int unsigned LO = lvl_off(n);
      logic [1:0]       m_q;
      logic [LVL_W-1:0] l_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            m_q <= 2'b00;
            l_q <= '0;
         end else begin
            if (wr_i && addr_i == ADDR_W'(MW)) m_q <= wdata_i[MO +: 2];
            if (wr_i && addr_i == ADDR_W'(LW)) l_q <= wdata_i[LO +: LVL_W];
         end
      end

      assign mode_o[n]  = m_q;
      assign level_o[n] = l_q;
      assign clr_o[n]   = clr_go && (wdata_i[CLR_SRC_W-1:0] == CLR_SRC_W'(n));
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == AD_EN)   rdata_o[0] = en_q;
      if (addr_i == AD_MASK) rdata_o[LVL_W-1:0] = mask_q;
      if (addr_i == AD_STAT) rdata_o = status_i;
      for (int n = 0; n < NSRC; n++) begin
         if (addr_i == ADDR_W'(mode_word(n)))
            rdata_o[mode_off(n) +: 2] = mode_o[n];
         if (addr_i == ADDR_W'(lvl_word(n)))
            rdata_o[lvl_off(n) +: LVL_W] = level_o[n];
      end
   end

   // R9: the clear command names at most one line per write
   a_r9_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_o));

endmodule

// File: rtl/prio_irq_src.sv
module prio_irq_src
   import prio_irq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_i,
   input  logic [1:0] mode_i,
   input  logic       clr_i,
   output logic       pend_o
);

   logic [1:0] sync_q;
   logic       prev_q;
   logic       pend_q;
   logic       pend_d;
   logic       s;

   assign s = sync_q[1];

   always_comb begin
      case (trig_e'(mode_i))
         TRIG_LOW:  pend_d = ~s;
         TRIG_HIGH: pend_d = s;
         TRIG_FALL: pend_d = (prev_q & ~s) | (pend_q & ~clr_i);
         TRIG_RISE: pend_d = (~prev_q & s) | (pend_q & ~clr_i);
         default:   pend_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= 2'b00;
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[0], req_i};
         prev_q <= s;
         pend_q <= pend_d;
      end
   end

   assign pend_o = pend_q;

   // R8: a latched edge survives any cycle without a clear
   a_r8_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[1] && pend_q && !clr_i) |=> pend_q);

   // R9: a clear with no fresh edge drops the latch
   a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[1] && clr_i && (s == prev_q)) |=> !pend_q);

   // R10: a level line with the input away from its polarity is idle next cycle
   a_r10_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i[1] && (s != mode_i[0])) |=> !pend_q);

endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
   import prio_irq_pkg::*;
#(
   parameter int unsigned NSRC  = 16,
   parameter int unsigned LVL_W = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       enable_i,
   input  logic [NSRC-1:0]            pend_i,
   input  logic [NSRC-1:0][LVL_W-1:0] level_i,
   input  logic [LVL_W-1:0]           mask_i,
   output logic                       no_irq_o,
   output logic [ST_SRC_W-1:0]        win_src_o,
   output logic [LVL_W-1:0]           win_lvl_o
);

   logic found;

   always_comb begin
      found     = 1'b0;
      win_src_o = '0;
      win_lvl_o = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (enable_i && pend_i[i] && (level_i[i] != '0) && (level_i[i] >= mask_i)
             && (!found || level_i[i] > win_lvl_o)) begin
            found     = 1'b1;
            win_lvl_o = level_i[i];
            win_src_o = ST_SRC_W'(i);
         end
      end
      no_irq_o = ~found;
   end

   // R5: a reported winner is never below the threshold
   a_r5_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
      !no_irq_o |-> (win_lvl_o >= mask_i));

   // R4: a reported winner never has priority zero
   a_r4_nonzero_level: assert property (@(posedge clk) disable iff (!rst_n)
      !no_irq_o |-> (win_lvl_o != '0));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int unsigned NSRC   = 16,
   parameter int unsigned LVL_W  = 3,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   req_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   output logic              cpu_irq_o
);

   if (NSRC < 1 || NSRC > 16) begin : g_bad_nsrc
      $error("prio_irq_ctrl: NSRC must lie in 1..16");
   end
   if (LVL_W < 1 || LVL_W > 3) begin : g_bad_lvl
      $error("prio_irq_ctrl: LVL_W must lie in 1..3");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("prio_irq_ctrl: ADDR_W must be at least 4");
   end

   logic                       enable;
   logic [NSRC-1:0][1:0]       mode;
   logic [NSRC-1:0][LVL_W-1:0] level;
   logic [LVL_W-1:0]           mask;
   logic [NSRC-1:0]            clr;
   logic [NSRC-1:0]            pend;
   logic                       no_irq;
   logic [ST_SRC_W-1:0]        win_src;
   logic [LVL_W-1:0]           win_lvl;
   logic [31:0]                status;
   logic                       irq_q;

   prio_irq_regs #(.NSRC(NSRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_i   (bus_addr_i),
      .wr_i     (bus_wr_i),
      .wdata_i  (bus_wdata_i),
      .status_i (status),
      .rdata_o  (bus_rdata_o),
      .enable_o (enable),
      .mode_o   (mode),
      .level_o  (level),
      .mask_o   (mask),
      .clr_o    (clr)
   );

   for (genvar n = 0; n < NSRC; n++) begin : g_src
      prio_irq_src u_src (
         .clk    (clk),
         .rst_n  (rst_n),
         .req_i  (req_i[n]),
         .mode_i (mode[n]),
         .clr_i  (clr[n]),
         .pend_o (pend[n])
      );
   end

   prio_irq_arb #(.NSRC(NSRC), .LVL_W(LVL_W)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable_i  (enable),
      .pend_i    (pend),
      .level_i   (level),
      .mask_i    (mask),
      .no_irq_o  (no_irq),
      .win_src_o (win_src),
      .win_lvl_o (win_lvl)
   );

   always_comb begin
      status                            = '0;
      status[ST_NOIRQ_BIT]              = no_irq;
      status[ST_LVL_LSB +: LVL_W]       = win_lvl;
      status[ST_SRC_W-1:0]              = win_src;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= ~no_irq;
   end

   assign cpu_irq_o = irq_q;

   // R2: with the global enable off nothing is reported
   a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> no_irq);

   // R11: the output is the previous cycle's pending indication
   a_r11_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cpu_irq_o == !$past(no_irq)));

   // R7: idle status carries empty fields
   a_r7_idle_fields: assert property (@(posedge clk) disable iff (!rst_n)
      no_irq |-> (win_src == '0 && win_lvl == '0));

endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] req = '0;
   logic [3:0]  addr = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        cpu_irq;

   int n_tests = 0;
   int n_fail  = 0;

   logic [1:0] tb_mode [16];
   int         tb_lvl  [16];
   bit         tb_latch[16];
   int         tb_mask;
   bit         tb_en;
   logic [15:0] tb_in;

   always #5 clk = ~clk;

   prio_irq_ctrl u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req),
      .bus_addr_i  (addr),
      .bus_wr_i    (wr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .cpu_irq_o   (cpu_irq)
   );

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got=timeout exp=done");
      summary();
   end

   task automatic chk(string req_tag, logic [31:0] got, logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h", req_tag, got, exp);
      end
   endtask

   task automatic bus_wr(int a, logic [31:0] d);
      @(negedge clk);
      addr = 4'(a); wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_rd(int a, output logic [31:0] d);
      @(negedge clk);
      addr = 4'(a); wr = 1'b0;
      #1 d = rdata;
   endtask

   task automatic peek(int a, output logic [31:0] d);
      addr = 4'(a);
      #1 d = rdata;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   task automatic drive(logic [15:0] v);
      @(negedge clk);
      tb_in = v; req = v;
      settle();
   endtask

   task automatic push_modes();
      for (int w = 0; w < 2; w++) begin
         logic [31:0] v = '0;
         for (int k = 0; k < 8; k++) v[k*2 +: 2] = tb_mode[w*8+k];
         bus_wr(1 + w, v);
      end
   endtask

   task automatic push_levels();
      for (int w = 0; w < 8; w++) begin
         logic [31:0] v = '0;
         v[2:0]  = 3'(tb_lvl[2*w]);
         v[10:8] = 3'(tb_lvl[2*w+1]);
         bus_wr(4 + w, v);
      end
   endtask

   function automatic logic [31:0] exp_status();
      int best = -1;
      int bl = 0;
      for (int n = 0; n < 16; n++) begin
         bit p = tb_mode[n][1] ? tb_latch[n] : (tb_in[n] == tb_mode[n][0]);
         if (tb_en && p && tb_lvl[n] != 0 && tb_lvl[n] >= tb_mask && tb_lvl[n] > bl) begin
            best = n; bl = tb_lvl[n];
         end
      end
      if (best < 0) return 32'h0001_0000;
      return (32'(bl) << 8) | 32'(best);
   endfunction

   task automatic check_status(string tag);
      logic [31:0] v;
      logic [31:0] e = exp_status();
      bus_rd(14, v);
      chk(tag, v, e);
      chk({tag, " R11 irq"}, {31'b0, cpu_irq}, {31'b0, ~e[16]});
   endtask

   initial begin
      logic [31:0] v;
      for (int n = 0; n < 16; n++) begin
         tb_mode[n] = 2'b00; tb_lvl[n] = 0; tb_latch[n] = 1'b0;
      end
      tb_mask = 0; tb_en = 1'b0; tb_in = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 and R12: reset values of every word
      for (int a = 0; a < 16; a++) begin
         bus_rd(a, v);
         chk($sformatf("R1 word %0d", a), v, (a == 14) ? 32'h0001_0000 : 32'h0);
      end
      chk("R1 irq", {31'b0, cpu_irq}, 32'h0);

      // R7: status ignores writes
      bus_wr(14, 32'hFFFF_FFFF);
      bus_rd(14, v);
      chk("R7 status write ignored", v, 32'h0001_0000);

      // R3, R4, R5, R12: field masks and positions on readback
      bus_wr(1, 32'h1234_5678);
      bus_rd(1, v); chk("R3 mode word 1", v, 32'h0000_5678);
      bus_wr(2, 32'hFFFF_FFFF);
      bus_rd(2, v); chk("R3 mode word 2", v, 32'h0000_FFFF);
      bus_wr(5, 32'h1234_5678);
      bus_rd(5, v); chk("R4 level pattern", v, 32'h0000_0600);
      bus_wr(11, 32'hFFFF_FFFF);
      bus_rd(11, v); chk("R4 level mask", v, 32'h0000_0707);
      bus_wr(12, 32'hFFFF_FFFF);
      bus_rd(12, v); chk("R5 mask readback", v, 32'h0000_0007);
      bus_wr(3, 32'hFFFF_FFFF);
      bus_rd(3, v); chk("R12 word 3", v, 32'h0);
      bus_wr(15, 32'hFFFF_FFFF);
      bus_rd(15, v); chk("R12 word 15", v, 32'h0);
      bus_rd(13, v); chk("R9 clear word reads zero", v, 32'h0);

      // back to a clean configuration
      for (int a = 1; a <= 12; a++) if (a != 3) bus_wr(a, 32'h0);
      settle();
      check_status("R4 all levels zero");

      // R2: global enable gates delivery
      tb_mode[5] = 2'b01; tb_lvl[5] = 5;
      push_modes(); push_levels();
      drive(16'h0020);
      check_status("R2 enable off");
      bus_wr(0, 32'h1); tb_en = 1'b1;
      settle();
      bus_rd(14, v);
      chk("R7 status fields", v, 32'h0000_0505);
      chk("R11 irq raised", {31'b0, cpu_irq}, 32'h1);

      // R5 and R6: sweep priorities, thresholds and request patterns
      for (int n = 0; n < 16; n++) tb_mode[n] = 2'b01;
      push_modes();
      for (int k = 0; k < 3; k++) begin
         for (int n = 0; n < 16; n++) tb_lvl[n] = (n * 5 + k * 3) % 8;
         push_levels();
         for (int m = 0; m < 8; m++) begin
            tb_mask = m;
            bus_wr(12, 32'(m));
            for (int p = 0; p < 3; p++) begin
               logic [15:0] pat;
               case (p)
                  0: pat = 16'hA5C3;
                  1: pat = 16'h1F08;
                  default: pat = 16'hFFFF;
               endcase
               drive((pat << k) | (pat >> (16 - k)));
               check_status($sformatf("R5 R6 sweep k=%0d m=%0d p=%0d", k, m, p));
            end
         end
      end

      // R6: ties go to the lowest line number
      for (int n = 0; n < 16; n++) tb_lvl[n] = 4;
      push_levels();
      tb_mask = 1; bus_wr(12, 32'h1);
      drive(16'h0F00);
      bus_rd(14, v);
      chk("R6 tie lowest number", v, 32'h0000_0408);

      // R3 and R10: active-low level line, not latched
      for (int n = 0; n < 16; n++) tb_lvl[n] = 0;
      tb_lvl[9] = 6; tb_mode[9] = 2'b00;
      push_levels(); push_modes();
      drive(16'hFFFF);
      check_status("R10 low line idle");
      drive(16'hFDFF);
      bus_rd(14, v);
      chk("R3 low level requests", v, 32'h0000_0609);
      drive(16'hFFFF);
      check_status("R10 released not latched");

      // R8 and R9: edge latches
      tb_lvl[9] = 0;
      tb_mode[9] = 2'b01;
      tb_mode[3] = 2'b11; tb_lvl[3] = 2;
      tb_mode[12] = 2'b10; tb_lvl[12] = 6;
      drive(16'h0000);
      push_modes(); push_levels();
      bus_wr(13, 32'h0000_0103);
      bus_wr(13, 32'h0000_010C);
      settle();
      check_status("R8 edge lines start clear");
      drive(16'h0008);
      tb_latch[3] = 1'b1;
      drive(16'h0000);
      bus_rd(14, v);
      chk("R8 rising edge held", v, 32'h0000_0203);
      bus_wr(13, 32'h0000_0003);
      settle();
      bus_rd(14, v);
      chk("R9 clear without go bit", v, 32'h0000_0203);
      drive(16'h1000);
      check_status("R8 rise ignored by falling line");
      drive(16'h0000);
      tb_latch[12] = 1'b1;
      bus_rd(14, v);
      chk("R8 falling edge held", v, 32'h0000_060C);
      bus_wr(13, 32'h0000_010C);
      tb_latch[12] = 1'b0;
      settle();
      check_status("R9 clear line 12");
      bus_wr(13, 32'h0000_0103);
      tb_latch[3] = 1'b0;
      peek(14, v);
      chk("R9 clear line 3", v, 32'h0001_0000);
      chk("R11 irq one cycle late", {31'b0, cpu_irq}, 32'h1);
      @(negedge clk);
      chk("R11 irq dropped", {31'b0, cpu_irq}, 32'h0);

      summary();
   end

endmodule